// File: doc/BRIEF.md
# Three-Phase Reset-Synchronous PWM Generator

This block drives three PWM phases from a single up-counter. The counter runs from zero to a programmable period value and then restarts at zero. That restart is the one edge every phase shares. Each phase then falls at its own compare point. Every phase has a true output and a complementary output. A seventh output changes level once per PWM period, so other logic can follow the cycle.

Software loads the period and three compare values through a single-cycle write port. Each write goes into a shadow copy. The active copies take the shadow values while the block is stopped, and again at every period restart, so a running period is never cut short.

The control state machine has two states, `ST_IDLE` and `ST_RUN`.
- START moves `ST_IDLE` to `ST_RUN` when `run_en` is high. The counter begins at zero and new values load.
- WRAP keeps the block in `ST_RUN` when the counter reaches the period. The counter goes back to zero, the values reload and the cycle output flips.
- STOP moves `ST_RUN` to `ST_IDLE` when `run_en` is low.

Top module: `tri_pwm_top`

## Requirements
- R1: Writes with `cfg_we` high go to shadow registers selected by `cfg_addr`: 0 is the period, 1, 2 and 3 are the compare values of phases 0, 1 and 2. A value written while stopped is in use from the first period after START.
- R2: While running, the counter steps 0, 1, ... up to the period value and then restarts, so one PWM period lasts period+1 clocks.
- R3: At every period start (START or WRAP), every phase whose compare value is non-zero drives its true output high. This is the common edge of all phases.
- R4: For a compare value c with 0 < c < period, the true output falls on the clock after the counter equals c, so it is high for c+1 clocks per period.
- R5: A compare value of zero keeps that phase's true output low for the whole period.
- R6: A compare value greater than or equal to the period keeps that phase's true output high for the whole period.
- R7: Each complementary output `pwm_lo[i]` is always the inverse of `pwm_hi[i]`, including in reset and while stopped.
- R8: `cyc_tgl` changes level exactly once per period, on the same clock as the WRAP. It is 0 after reset.
- R9: A write made while running does not change the period or duty of the period in progress. It applies from the next WRAP on.
- R10: While `run_en` is low, the counter holds at zero, `pwm_hi` is all zero, `pwm_lo` is all one and `cyc_tgl` keeps its level.
- R11: A period value of zero gives a one-clock period: `cyc_tgl` flips on every clock and each true output is constantly high or low according to its compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High to run the counter, low to stop |
| cfg_we | input | 1 | Write strobe for the shadow registers |
| cfg_addr | input | 2 | Register select: 0 period, 1 to 3 phase compare |
| cfg_wdata | input | 16 | Write data |
| pwm_hi | output | 3 | True PWM output per phase |
| pwm_lo | output | 3 | Complementary PWM output per phase |
| cyc_tgl | output | 1 | Flips once per PWM period |

## Verification
A wrong counter or a wrong active period shows as a wrong spacing between `cyc_tgl` changes. This is visible within one period. A wrong compare match or a missed set at the common edge shows as a wrong high-time count on the affected `pwm_hi` bit in the same period. A premature shadow load shows one period early: the period in which the write happens already has the new length or duty, where it should keep the old values. A stuck state register shows within one clock of `run_en` falling: the outputs fail to go to their stopped levels, or `cyc_tgl` keeps moving.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_st_e;

    localparam int unsigned PERIOD_ADDR = 0;

endpackage

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs #(
    parameter int unsigned W  = 16,
    parameter int unsigned N  = 3,
    parameter int unsigned AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [W-1:0]        cfg_wdata,
    input  logic                take,
    output logic [W-1:0]        per_act,
    output logic [N-1:0][W-1:0] cmp_shd,
    output logic [N-1:0][W-1:0] cmp_act
);
    import tri_pwm_pkg::*;

    logic [W-1:0] per_shd;

    // Shadow copies: written by the port at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_shd <= '0;
            cmp_shd <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == AW'(PERIOD_ADDR)) per_shd <= cfg_wdata;
            for (int i = 0; i < int'(N); i++) begin
                if (cfg_addr == AW'(i + 1)) cmp_shd[i] <= cfg_wdata;
            end
        end
    end

    // Active copies: follow the shadows only when stopped or at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= '0;
            cmp_act <= '0;
        end else if (take) begin
            per_act <= per_shd;
            cmp_act <= cmp_shd;
        end
    end

    // R9: active values never move between wraps
    p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(per_act) && $stable(cmp_act)));

endmodule

// File: rtl/tri_pwm_ctrl.sv
module tri_pwm_ctrl #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt,
    output logic         take,
    output logic         ld,
    output logic         cyc_tgl
);
    import tri_pwm_pkg::*;

    pwm_st_e st, st_nxt;
    logic    wrap;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: st_nxt = run_en ? ST_RUN : ST_IDLE;   // START
            ST_RUN:  st_nxt = run_en ? ST_RUN : ST_IDLE;   // WRAP / STOP
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    assign wrap = (st == ST_RUN) && (cnt == per_act);
    assign take = (st == ST_IDLE) || wrap;
    assign ld   = run_en && take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cyc_tgl <= 1'b0;
        end else begin
            if (!run_en || take) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
            if (run_en && wrap)  cyc_tgl <= ~cyc_tgl;
        end
    end

    // R2: the counter never passes the active period while running
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (cnt <= per_act));
    // R8: no toggle in the middle of a period
    p_tgl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUN) && (cnt != per_act)) |=> $stable(cyc_tgl));
    // R10: stopping clears the counter and parks the toggle
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ((cnt == '0) && (st == ST_IDLE) && $stable(cyc_tgl)));

endmodule

// File: rtl/tri_pwm_phase.sv
module tri_pwm_phase #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         ld,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    input  logic [W-1:0] cmp_shd,
    output logic         hi,
    output logic         lo
);

    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            hi <= 1'b0;
            lo <= 1'b1;
        end else if (ld) begin
            hi <= (cmp_shd != '0);
            lo <= (cmp_shd == '0);
        end else if (cnt == cmp_act) begin
            hi <= 1'b0;
            lo <= 1'b1;
        end
    end

    // R7: the two outputs are held in separate flops and must stay opposite
    p_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hi != lo);
    // R3: common rising edge at every period start
    p_common_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && (cmp_shd != '0)) |=> hi);
    // R5: a zero compare keeps the phase low
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && (cmp_shd == '0)) |=> !hi);
    // R4: once low inside a period, stays low until the next start
    p_stay_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !ld && !hi) |=> !hi);

endmodule

// File: rtl/tri_pwm_top.sv
module tri_pwm_top #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_PH  = 3,
    localparam int unsigned AW   = $clog2(N_PH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [N_PH-1:0]  pwm_hi,
    output logic [N_PH-1:0]  pwm_lo,
    output logic             cyc_tgl
);

    logic [CNT_W-1:0]            per_act;
    logic [N_PH-1:0][CNT_W-1:0]  cmp_shd;
    logic [N_PH-1:0][CNT_W-1:0]  cmp_act;
    logic [CNT_W-1:0]            cnt;
    logic                        take;
    logic                        ld;

    tri_pwm_regs #(.W(CNT_W), .N(N_PH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .take      (take),
        .per_act   (per_act),
        .cmp_shd   (cmp_shd),
        .cmp_act   (cmp_act)
    );

    tri_pwm_ctrl #(.W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .per_act (per_act),
        .cnt     (cnt),
        .take    (take),
        .ld      (ld),
        .cyc_tgl (cyc_tgl)
    );

    for (genvar g = 0; g < N_PH; g++) begin : g_ph
        tri_pwm_phase #(.W(CNT_W)) u_ph (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_en  (run_en),
            .ld      (ld),
            .cnt     (cnt),
            .cmp_act (cmp_act[g]),
            .cmp_shd (cmp_shd[g]),
            .hi      (pwm_hi[g]),
            .lo      (pwm_lo[g])
        );
    end

endmodule

// File: tb/tb_tri_pwm_top.sv
module tb_tri_pwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  pwm_hi;
    logic [2:0]  pwm_lo;
    logic        cyc_tgl;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;   // 250 MHz

    tri_pwm_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pwm_hi    (pwm_hi),
        .pwm_lo    (pwm_lo),
        .cyc_tgl   (cyc_tgl)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_high(input int c, input int p);
        if (c == 0)  return 0;
        if (c >= p)  return p + 1;
        return c + 1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    // Starts at the first cycle of a period, ends at the first cycle of the next
    task automatic run_period(input int exp_len, input int e0, input int e1, input int e2,
                              input string req, input bit mid_wr,
                              input logic [15:0] np, input logic [15:0] nc0);
        logic t0 = cyc_tgl;
        int   len = 0;
        int   hc[3] = '{0, 0, 0};
        int   exp_h[3];
        bit   cbad = 1'b0;
        exp_h[0] = e0; exp_h[1] = e1; exp_h[2] = e2;
        for (int i = 0; i < 3; i++)
            check(pwm_hi[i] == (exp_h[i] > 0), {req, " R3 start level"}, int'(pwm_hi[i]), int'(exp_h[i] > 0));
        do begin
            for (int i = 0; i < 3; i++) if (pwm_hi[i]) hc[i]++;
            if (pwm_lo !== ~pwm_hi) cbad = 1'b1;
            len++;
            if (mid_wr && len == 1) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = np; end
            if (mid_wr && len == 2) begin cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = nc0; end
            if (mid_wr && len == 3) cfg_we = 1'b0;
            step();
        end while (cyc_tgl == t0 && len < 300);
        cfg_we = 1'b0;
        check(len == exp_len, {req, " R2 R8 period length"}, len, exp_len);
        for (int i = 0; i < 3; i++)
            check(hc[i] == exp_h[i], {req, " high time"}, hc[i], exp_h[i]);
        check(!cbad, "R7 complement", int'(cbad), 0);
    endtask

    task automatic t_reset();
        step(); step();
        check(pwm_hi == 3'b000, "R10 reset hi", pwm_hi, 0);
        check(pwm_lo == 3'b111, "R7 reset lo", pwm_lo, 7);
        check(cyc_tgl == 1'b0, "R8 reset toggle", cyc_tgl, 0);
    endtask

    task automatic t_basic();
        // R1: addr 0 period, 1..3 compares of phases 0..2, written while stopped
        wr(2'd0, 16'd9); wr(2'd1, 16'd3); wr(2'd2, 16'd0); wr(2'd3, 16'd20);
        run_en = 1'b1;
        step();
        run_period(10, exp_high(3, 9), exp_high(0, 9), exp_high(20, 9), "R1 R4 R5 R6", 1'b0, '0, '0);
        run_period(10, 4, 0, 10, "R4 R5 R6 repeat", 1'b0, '0, '0);
    endtask

    task automatic t_shadow();
        // R9: new period 5 and compare0 5 written mid-period
        run_period(10, 4, 0, 10, "R9 old values kept", 1'b1, 16'd5, 16'd5);
        run_period(6, exp_high(5, 5), 0, exp_high(20, 5), "R9 new values", 1'b0, '0, '0);
    endtask

    task automatic t_stop_restart();
        logic t;
        run_en = 1'b0;
        t = cyc_tgl;
        step();
        check(pwm_hi == 3'b000, "R10 stop hi", pwm_hi, 0);
        check(pwm_lo == 3'b111, "R10 stop lo", pwm_lo, 7);
        wr(2'd2, 16'd1); wr(2'd3, 16'd2);
        repeat (5) step();
        check(cyc_tgl == t, "R10 toggle held", cyc_tgl, t);
        check(pwm_hi == 3'b000, "R10 still stopped", pwm_hi, 0);
        run_en = 1'b1;
        step();
        run_period(6, 6, 2, 3, "R1 restart", 1'b0, '0, '0);
    endtask

    task automatic t_zero_period();
        logic prev;
        run_en = 1'b0;
        step();
        wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd1); wr(2'd3, 16'd0);
        run_en = 1'b1;
        step();
        prev = cyc_tgl;
        for (int k = 0; k < 4; k++) begin
            check(pwm_hi == 3'b010, "R11 levels", pwm_hi, 2);
            step();
            check(cyc_tgl != prev, "R11 toggle every clock", cyc_tgl, !prev);
            prev = cyc_tgl;
        end
        run_en = 1'b0;
        step();
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                t_reset();
                t_basic();
                t_shadow();
                t_stop_restart();
                t_zero_period();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule